// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Target

This block is the target side of a two-wire serial bus (I2C) that gives a bus controller read and write access to a small on-chip byte memory. By default the memory holds 256 bytes (2 Kbit). SCL and SDA are oversampled with the fast system clock. The block finds START and STOP conditions, checks the target address byte, acknowledges and takes in write data, and shifts out read data. SDA leaves the block as an open-drain enable: while `sda_oe` is high the line is pulled low.

The address byte starts with the fixed nibble 1010. Three extension bits follow it, and then the direction bit. The parameter `INT_BITS` decides how many of the low extension bits act as memory address bits. The remaining upper extension bits are compared with the `addr_pins_i` strap inputs. Writes collect their bytes in a page buffer. A STOP then copies the buffer into the array and starts a timed write-cycle period. During that period the block answers nothing, so a controller can poll for completion. An address pointer survives between transactions, which makes current-address reads possible.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While reset is asserted, `sda_oe` is low, so SDA is released.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After reset, and after any STOP, the block ignores every bit until a START arrives, and it does not acknowledge a byte clocked without one.
- R3: An address byte is accepted only when bits 7..4 equal 1010 and each extension bit i (byte bit i+1) with i >= `INT_BITS` equals `addr_pins_i[i]`. Bit 0 selects read (1) or write (0). A match is acknowledged by driving SDA low for the whole 9th clock. A mismatch leaves SDA released, and the block waits for the next START.
- R4: In a write, the first byte after the address is the word address (memory address bits 7..0), and every further byte is stored. Each of these bytes is acknowledged. Stored bytes reach the memory only at the STOP. An address-only write changes no memory location and starts no write cycle.
- R5: Data bytes go to a 16-byte page. The low 4 address bits advance after each byte and wrap within the page, and the upper bits stay fixed.
- R6: After a STOP commits data, the block does not acknowledge any address byte for `WR_CYCLES` system clocks. After that period it acknowledges again.
- R7: Read bytes come from the current address, most significant bit first. Each bit is driven after an SCL fall, and SDA is released during the 9th clock. The address advances by one after each byte, across page boundaries, wrapping at the top of the memory. Reading continues while the controller acknowledges and stops at a non-acknowledge.
- R8: The address pointer is kept between transactions. A read with no preceding word address continues from the address after the last byte read or written.
- R9: A repeated START in the middle of a transaction drops the byte in progress and the buffered write data. It restarts address matching, commits nothing and starts no write cycle.
- R10: A STOP after a read returns the block to standby, where it ignores traffic until the next START.
- R11: Extension bits below `INT_BITS` supply memory address bits 8 and up, taken from byte bits 1 and up. With `INT_BITS`=1, the same word address with extension bit 0 clear or set reaches two distinct locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| addr_pins_i | input | 3 | Strap inputs compared with chip-select extension bits |

## Verification
Most wrong internal states show up at SDA within one byte time. A wrong bit counter or phase moves the acknowledge off the 9th clock or corrupts a shifted read byte. A stale busy counter turns an expected acknowledge into a non-acknowledge on the next poll. Errors in the page offset, the pointer or the commit path stay hidden until a later read. The bench therefore reads every written location back, and also reads the neighbours a wrong wrap or a premature commit would have touched.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         EXT_BITS   = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WORD,
    PH_WDATA,
    PH_ACK,
    PH_RDATA,
    PH_MACK
  } phase_t;

  // Address byte match: prefix nibble plus the extension bits that act as chip selects.
  function automatic logic dev_match(input logic [7:0] b,
                                     input logic [EXT_BITS-1:0] pins,
                                     input int n_int);
    logic ok;
    ok = (b[7:4] == DEV_PREFIX);
    for (int i = 0; i < EXT_BITS; i++) begin
      if (i >= n_int && b[i+1] != pins[i]) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_m, scl_s, scl_d;
  logic sda_m, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      scl_s <= 1'b1;
      scl_d <= 1'b1;
      sda_m <= 1'b1;
      sda_s <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i;
      scl_s <= scl_m;
      scl_d <= scl_s;
      sda_m <= sda_i;
      sda_s <= sda_m;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_eeprom_store.sv
module i2c_eeprom_store #(
  parameter  int AW         = 8,
  parameter  int PAGE_BYTES = 16,
  parameter  int WR_CYCLES  = 2000,
  localparam int PB         = $clog2(PAGE_BYTES),
  localparam int DEPTH      = 1 << AW,
  localparam int CW         = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_we,
  input  logic [PB-1:0]    buf_off,
  input  logic [7:0]       buf_din,
  input  logic             buf_clr,
  input  logic             commit,
  input  logic [AW-PB-1:0] commit_page,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             busy
);

  logic [7:0]            mem  [DEPTH];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;
  logic [CW-1:0]         wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvalid   <= '0;
      wait_cnt <= '0;
    end else begin
      if (commit) begin
        pvalid   <= '0;
        wait_cnt <= CW'(WR_CYCLES);
      end else begin
        if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
        if (buf_clr)       pvalid <= '0;
        else if (buf_we)   pvalid[buf_off] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_off] <= buf_din;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (commit && pvalid[i]) mem[{commit_page, PB'(i)}] <= pbuf[i];
    end
  end

  assign rd_data = mem[rd_addr];
  assign busy    = (wait_cnt != '0);

endmodule

// File: rtl/i2c_eeprom_ctrl.sv
module i2c_eeprom_ctrl
  import i2c_eeprom_pkg::*;
#(
  parameter  int INT_BITS   = 0,
  parameter  int PAGE_BYTES = 16,
  localparam int AW         = 8 + INT_BITS,
  localparam int PB         = $clog2(PAGE_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_evt,
  input  logic                stop_evt,
  input  logic [EXT_BITS-1:0] pins_i,
  input  logic                busy_i,
  input  logic [7:0]          rd_data_i,
  output logic                sda_oe,
  output logic [AW-1:0]       rd_addr,
  output logic                buf_we,
  output logic [PB-1:0]       buf_off,
  output logic [7:0]          buf_din,
  output logic                buf_clr,
  output logic                commit,
  output logic [AW-PB-1:0]    commit_page
);

  phase_t        ph, nxt_ph;
  logic [3:0]    bit_cnt;
  logic [7:0]    sh;
  logic [AW-1:0] cur_addr;
  logic          wr_pending;
  logic          byte_in_done;

  function automatic logic [AW-1:0] with_hi(input logic [AW-1:0] a, input logic [7:0] dev);
    logic [AW-1:0] r;
    r = a;
    for (int i = 0; i < INT_BITS; i++) r[8+i] = dev[1+i];
    return r;
  endfunction

  function automatic logic [AW-1:0] with_low(input logic [AW-1:0] a, input logic [7:0] w);
    logic [AW-1:0] r;
    r      = a;
    r[7:0] = w;
    return r;
  endfunction

  function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r         = a;
    r[PB-1:0] = a[PB-1:0] + 1'b1;
    return r;
  endfunction

  assign byte_in_done = scl_fall && (bit_cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      nxt_ph     <= PH_IDLE;
      bit_cnt    <= '0;
      sh         <= '0;
      cur_addr   <= '0;
      wr_pending <= 1'b0;
      sda_oe     <= 1'b0;
      commit     <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start_evt) begin
        ph         <= PH_DEV;
        bit_cnt    <= '0;
        sda_oe     <= 1'b0;
        wr_pending <= 1'b0;
      end else if (stop_evt) begin
        commit     <= wr_pending;
        wr_pending <= 1'b0;
        ph         <= PH_IDLE;
        sda_oe     <= 1'b0;
      end else begin
        case (ph)
          PH_DEV, PH_WORD, PH_WDATA: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              sh      <= {sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_in_done) begin
              bit_cnt <= '0;
              ph      <= PH_ACK;
              sda_oe  <= 1'b1;
              if (ph == PH_DEV) begin
                if (dev_match(sh, pins_i, INT_BITS) && !busy_i) begin
                  cur_addr <= with_hi(cur_addr, sh);
                  nxt_ph   <= sh[0] ? PH_RDATA : PH_WORD;
                end else begin
                  ph     <= PH_IDLE;
                  sda_oe <= 1'b0;
                end
              end else if (ph == PH_WORD) begin
                cur_addr <= with_low(cur_addr, sh);
                nxt_ph   <= PH_WDATA;
              end else begin
                cur_addr   <= page_next(cur_addr);
                wr_pending <= 1'b1;
                nxt_ph     <= PH_WDATA;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (nxt_ph == PH_RDATA) begin
                sh       <= rd_data_i;
                sda_oe   <= ~rd_data_i[7];
                cur_addr <= cur_addr + 1'b1;
                bit_cnt  <= 4'd1;
                ph       <= PH_RDATA;
              end else begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                ph      <= nxt_ph;
              end
            end
          end
          PH_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                ph     <= PH_MACK;
              end else begin
                sda_oe  <= ~sh[6];
                sh      <= {sh[6:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise && sda_s) begin
              ph <= PH_IDLE;
            end else if (scl_fall) begin
              sh       <= rd_data_i;
              sda_oe   <= ~rd_data_i[7];
              cur_addr <= cur_addr + 1'b1;
              bit_cnt  <= 4'd1;
              ph       <= PH_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    buf_we      = (ph == PH_WDATA) && byte_in_done && !start_evt && !stop_evt;
    buf_off     = cur_addr[PB-1:0];
    buf_din     = sh;
    buf_clr     = start_evt;
    rd_addr     = cur_addr;
    commit_page = cur_addr[AW-1:PB];
  end

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter int INT_BITS   = 0,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] addr_pins_i
);

  localparam int AW = 8 + INT_BITS;
  localparam int PB = $clog2(PAGE_BYTES);

  logic             sda_s_w;
  logic             scl_rise_w, scl_fall_w;
  logic             start_w, stop_w;
  logic             busy_w, commit_w;
  logic             buf_we_w, buf_clr_w;
  logic [PB-1:0]    buf_off_w;
  logic [7:0]       buf_din_w, rd_data_w;
  logic [AW-1:0]    rd_addr_w;
  logic [AW-PB-1:0] commit_page_w;

  i2c_bus_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s_w),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_evt (start_w),
    .stop_evt  (stop_w)
  );

  i2c_eeprom_ctrl #(
    .INT_BITS   (INT_BITS),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_s       (sda_s_w),
    .scl_rise    (scl_rise_w),
    .scl_fall    (scl_fall_w),
    .start_evt   (start_w),
    .stop_evt    (stop_w),
    .pins_i      (addr_pins_i),
    .busy_i      (busy_w),
    .rd_data_i   (rd_data_w),
    .sda_oe      (sda_oe),
    .rd_addr     (rd_addr_w),
    .buf_we      (buf_we_w),
    .buf_off     (buf_off_w),
    .buf_din     (buf_din_w),
    .buf_clr     (buf_clr_w),
    .commit      (commit_w),
    .commit_page (commit_page_w)
  );

  i2c_eeprom_store #(
    .AW         (AW),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_we      (buf_we_w),
    .buf_off     (buf_off_w),
    .buf_din     (buf_din_w),
    .buf_clr     (buf_clr_w),
    .commit      (commit_w),
    .commit_page (commit_page_w),
    .rd_addr     (rd_addr_w),
    .rd_data     (rd_data_w),
    .busy        (busy_w)
  );

endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic commit,
  input logic busy
);

  always @(posedge clk) begin
    if (!rst_n) begin
      // R1
      reset_release_chk: assert (sda_oe == 1'b0);
    end
  end

  // R7
  drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R3
  release_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

  // R4
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_evt));

  // R6
  busy_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && !commit));

endmodule

bind i2c_eeprom_slave i2c_eeprom_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .scl_fall  (scl_fall_w),
  .start_evt (start_w),
  .stop_evt  (stop_w),
  .commit    (commit_w),
  .busy      (busy_w)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;

  localparam int WR = 2000;
  localparam int Q  = 10;
  localparam logic [7:0] D0W = 8'hA6;  // 1010 011 0
  localparam logic [7:0] D0R = 8'hA7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic oe0, oe1;
  logic sda_line;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~oe0 & ~oe1;

  i2c_eeprom_slave #(.INT_BITS(0), .WR_CYCLES(WR)) u_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(oe0), .addr_pins_i(3'b011));

  i2c_eeprom_slave #(.INT_BITS(1), .WR_CYCLES(WR)) u_hi (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(oe1), .addr_pins_i(3'b100));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b, output logic ninth);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      b = {b[6:0], sda_line};
      tick(Q);
      m_scl = 1'b0;
    end
    m_sda = !mack; tick(Q);
    m_scl = 1'b1; tick(Q);
    ninth = sda_line;
    tick(Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic poll(input logic [7:0] dev, output bit acked);
    bus_start();
    write_byte(dev, acked);
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] wdev, input logic [7:0] word, output logic [7:0] d);
    bit a1, a2, a3;
    logic n;
    bus_start();
    write_byte(wdev, a1);
    write_byte(word, a2);
    bus_start();
    write_byte(wdev | 8'h01, a3);
    read_byte(1'b0, d, n);
    bus_stop();
    check("R7 random read address acks", {a1, a2, a3}, 3'b111);
  endtask

  task automatic write_one(input logic [7:0] dev, input logic [7:0] word, input logic [7:0] data);
    bit a1, a2, a3;
    bus_start();
    write_byte(dev, a1);
    write_byte(word, a2);
    write_byte(data, a3);
    bus_stop();
    check("R4 byte write acks", {a1, a2, a3}, 3'b111);
    tick(WR + 50);
  endtask

  task automatic stray_byte(output bit acked);
    m_scl = 1'b0; tick(Q);
    write_byte(D0W, acked);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
  endtask

  task automatic t_reset();
    check("R1 sda_oe in reset (dev0)", oe0, 1'b0);
    check("R1 sda_oe in reset (dev1)", oe1, 1'b0);
  endtask

  task automatic t_no_start();
    bit a;
    stray_byte(a);
    check("R2 byte without START not acked", a, 1'b0);
  endtask

  task automatic t_addr();
    bit a, b;
    poll(8'hB6, a);
    check("R3 wrong prefix nack", a, 1'b0);
    poll(8'hA0, a);
    check("R3 wrong pins nack", a, 1'b0);
    poll(D0W, a);
    poll(D0W, b);
    check("R3 matching address ack", a, 1'b1);
    check("R4 address-only write starts no busy", b, 1'b1);
  endtask

  task automatic t_byte_write();
    bit a1, a2, a3, p;
    logic [7:0] d;
    bus_start();
    write_byte(D0W, a1);
    write_byte(8'h40, a2);
    write_byte(8'h5A, a3);
    bus_stop();
    check("R4 write acks", {a1, a2, a3}, 3'b111);
    poll(D0W, p);
    check("R6 address nacked while busy", p, 1'b0);
    tick(WR);
    poll(D0W, p);
    check("R6 address acked after busy", p, 1'b1);
    rand_read(D0W, 8'h40, d);
    check("R4 byte committed at STOP", d, 8'h5A);
  endtask

  task automatic t_page();
    bit a;
    bit [5:0] acks;
    logic [7:0] d;
    logic n;
    bus_start();
    write_byte(D0W, acks[0]);
    write_byte(8'h3C, acks[1]);
    for (int i = 0; i < 5; i++) begin
      write_byte(8'h10 + 8'(i), a);
      acks = {acks[4:0], a};
    end
    bus_stop();
    check("R5 page write acks", acks, 6'h3F);
    tick(WR + 50);
    rand_read(D0W, 8'h30, d);
    check("R5 fifth byte wrapped to page start", d, 8'h14);
    rand_read(D0W, 8'h40, d);
    check("R5 next page untouched", d, 8'h5A);
    bus_start();
    write_byte(D0W, a);
    write_byte(8'h3C, a);
    bus_start();
    write_byte(D0R, a);
    for (int i = 0; i < 4; i++) begin
      read_byte(1'b1, d, n);
      check("R7 sequential read byte", d, 8'h10 + 8'(i));
    end
    read_byte(1'b0, d, n);
    check("R7 read crosses page boundary", d, 8'h5A);
    check("R7 SDA released on 9th clock", n, 1'b1);
    bus_stop();
  endtask

  task automatic t_current();
    bit a;
    logic [7:0] d;
    logic n;
    rand_read(D0W, 8'h3E, d);
    check("R7 random read", d, 8'h12);
    bus_start();
    write_byte(D0R, a);
    read_byte(1'b0, d, n);
    bus_stop();
    check("R8 current address read ack", a, 1'b1);
    check("R8 current address read data", d, 8'h13);
  endtask

  task automatic t_restart();
    bit a1, a2, a3, p;
    logic [7:0] d;
    bus_start();
    write_byte(D0W, a1);
    write_byte(8'h30, a2);
    write_byte(8'h99, a3);
    check("R9 write before restart acked", {a1, a2, a3}, 3'b111);
    rand_read(D0W, 8'h30, d);
    check("R9 aborted write not committed", d, 8'h14);
    poll(D0W, p);
    check("R9 no write cycle after abort", p, 1'b1);
  endtask

  task automatic t_standby();
    bit a;
    logic [7:0] d;
    rand_read(D0W, 8'h40, d);
    stray_byte(a);
    check("R10 standby after read STOP", a, 1'b0);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    write_one(8'hA8, 8'h05, 8'h11);
    write_one(8'hAA, 8'h05, 8'h77);
    rand_read(8'hA8, 8'h05, d);
    check("R11 internal bit clear", d, 8'h11);
    rand_read(8'hAA, 8'h05, d);
    check("R11 internal bit set", d, 8'h77);
  endtask

  initial begin
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(5);
    t_no_start();
    t_addr();
    t_byte_write();
    t_page();
    t_current();
    t_restart();
    t_standby();
    t_ext();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule